// File: doc/BRIEF.md
# ZQ Calibration Interval Pacer

This block sets the pace of periodic short impedance (ZQ) calibration in a DDR3 memory controller. Software writes a 16-bit interval into one control register that sits behind a simple register port. The interval is counted in average refresh intervals: the block gets one strobe per refresh interval on `ref_tick`, not one per clock. When the countdown runs out, the block asks the command sequencer for one short calibration command. Then it reloads the interval and goes on counting.

The request is a level. It stays high until the sequencer sends back an acknowledge. If the timer runs out again while a request is still waiting, no second request is queued. Writing zero to the interval stops periodic calibration. Writing a new nonzero value starts the countdown again from that value. While the write-protect input is high, the block ignores every register write. As a worked figure, a 0.4 s period with a 7.8 µs refresh interval needs an interval value of 0xC852.

Top module: `zq_cal_pacer`

## Requirements
- R1: After reset, the interval field is 0, a read at byte address 0x2C returns 0, and `cal_req` is low.
- R2: The interval register is at byte address 0x2C. It holds the interval in bits 15:0, and bits 31:16 read as zero. A read at any other address returns zero, and a write to any other address leaves the interval unchanged. With the default options, reads are combinational.
- R3: While `wp_en` is high, a write to 0x2C is ignored and the interval keeps its old value.
- R4: After a nonzero value N is written, `cal_req` rises in the clock cycle that follows the clock edge sampling the Nth `ref_tick` pulse after the write. Earlier ticks raise nothing.
- R5: `cal_req` stays high until `cal_ack` is sampled high. It is low in the cycle after that acknowledge.
- R6: When the countdown expires, the timer reloads the current interval and keeps counting. The next expiry comes N ticks later, whether or not the earlier request has been acknowledged.
- R7: An expiry that happens while `cal_req` is still high is dropped. Once acknowledged, no request appears until the next expiry.
- R8: An interval of 0 disables calibration, and no request rises however many ticks arrive.
- R9: Writing a new nonzero value while a countdown is running restarts the countdown from the new value.
- R10: Clock cycles without a `ref_tick` pulse never advance the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register byte address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| wp_en | input | 1 | Write protect; blocks register writes while high |
| ref_tick | input | 1 | One-cycle strobe per average refresh interval |
| cal_ack | input | 1 | Sequencer acknowledge of the calibration request |
| cal_req | output | 1 | Pending short-calibration request |

## Verification
The hardest case to create from the ports is a timer expiry while the previous request is still waiting. It has to be dropped without disturbing the reload. The stimulus programs a short interval and then withholds the acknowledge across a full extra interval of ticks. It then acknowledges and confirms that the next rise comes exactly one interval after the dropped expiry. A scoreboard model predicts which tick number should raise each request. Restarts in the middle of a countdown, the one-tick interval and the zero interval are driven through the same model.

// File: rtl/zqcal_pkg.sv
package zqcal_pkg;
   typedef enum logic {
      RD_COMB = 1'b0,
      RD_REG  = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/zqcal_ctrl_reg.sv
module zqcal_ctrl_reg
   import zqcal_pkg::*;
#(
   parameter int unsigned            ADDR_W     = 8,
   parameter int unsigned            DATA_W     = 32,
   parameter int unsigned            CNT_W      = 16,
   parameter logic [ADDR_W-1:0]      REG_OFFSET = 8'h2C,
   parameter rd_mode_e               RD_MODE    = RD_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wp_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  field,
   output logic              load,
   output logic [CNT_W-1:0]  load_val
);
   localparam int unsigned PAD_W = DATA_W - CNT_W;

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_width
      $error("zqcal_ctrl_reg: CNT_W must be 1..DATA_W");
   end
   if (REG_OFFSET[1:0] != 2'b00) begin : g_bad_offset
      $error("zqcal_ctrl_reg: REG_OFFSET must be word aligned");
   end

   logic hit;
   assign hit      = (addr == REG_OFFSET);
   assign load     = wr_en && hit && !wp_en;
   assign load_val = wr_data[CNT_W-1:0];

   if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:CNT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field <= '0;
      else if (load)
         field <= load_val;
   end

   logic [DATA_W-1:0] rd_next;
   assign rd_next = hit ? DATA_W'(field) : '0;

   if (RD_MODE == RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_data <= '0;
         else
            rd_data <= rd_next;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_next;
   end

   // R3: a protected write leaves the interval untouched
   a_r3_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wp_en) |=> $stable(field));
   // R2: writes elsewhere do not reach the interval
   a_r2_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> $stable(field));
endmodule

// File: rtl/zqcal_interval_timer.sv
module zqcal_interval_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] field,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_width
      $error("zqcal_interval_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign expire = tick && !load && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (tick && cnt != '0)
         cnt <= (cnt == ONE) ? field : cnt - ONE;
   end

   // R6: expiry reloads the programmed interval
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == $past(field)));
   // R10: no tick, no movement
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
   // R4: countdown never exceeds the programmed interval
   a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= field);
endmodule

// File: rtl/zqcal_req_hold.sv
module zqcal_req_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic ack,
   output logic req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req <= 1'b0;
      else if (expire)
         req <= 1'b1;
      else if (ack)
         req <= 1'b0;
   end

   // R5: request held until acknowledged
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> req);
   // R5: acknowledge clears the request
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !expire) |=> !req);
   // R4: a request only rises from a timer expiry
   a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(expire));
endmodule

// File: rtl/zq_cal_pacer.sv
module zq_cal_pacer
   import zqcal_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       CNT_W      = 16,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h2C,
   parameter rd_mode_e          RD_MODE    = RD_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wr_data,
   output logic [DATA_W-1:0] reg_rd_data,
   input  logic              wp_en,
   input  logic              ref_tick,
   input  logic              cal_ack,
   output logic              cal_req
);
   logic [CNT_W-1:0] field;
   logic [CNT_W-1:0] load_val;
   logic             load;
   logic             expire;

   zqcal_ctrl_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .REG_OFFSET(REG_OFFSET), .RD_MODE(RD_MODE)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr_en),
      .wr_data(reg_wr_data), .wp_en(wp_en), .rd_data(reg_rd_data),
      .field(field), .load(load), .load_val(load_val)
   );

   zqcal_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick), .load(load),
      .load_val(load_val), .field(field), .expire(expire)
   );

   zqcal_req_hold u_req (
      .clk(clk), .rst_n(rst_n), .expire(expire), .ack(cal_ack), .req(cal_req)
   );

   // R8: zero interval never raises a request
   a_r8_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (field == '0 && !cal_req) |=> !cal_req);
endmodule

// File: tb/tb_zq_cal_pacer.sv
module tb_zq_cal_pacer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = 8'h2C;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic        wp_en = 1'b0;
   logic        ref_tick = 1'b0;
   logic        cal_ack = 1'b0;
   logic        cal_req;

   always #10 clk = ~clk;

   zq_cal_pacer dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .wp_en(wp_en),
      .ref_tick(ref_tick), .cal_ack(cal_ack), .cal_req(cal_req)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   int     tick_no = 0;
   int     m_field = 0;
   int     m_cnt = 0;
   bit     m_pend = 1'b0;
   int     exp_q[$];
   string  tag_q[$];
   string  cur_tag = "R4";

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
      if (!wp_en && a == 8'h2C) begin
         m_field = int'(d[15:0]);
         m_cnt   = m_field;
      end
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = 8'h2C;
   endtask

   task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rd_data === exp, reg_rd_data, exp);
      reg_addr = 8'h2C;
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      ref_tick = 1'b1;
      tick_no++;
      if (m_cnt != 0) begin
         if (m_cnt == 1) begin
            m_cnt = m_field;
            if (!m_pend) begin
               m_pend = 1'b1;
               exp_q.push_back(tick_no);
               tag_q.push_back(tag);
            end
         end else begin
            m_cnt--;
         end
      end
      @(negedge clk);
      ref_tick = 1'b0;
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   task automatic ack_req();
      @(negedge clk);
      cal_ack = 1'b1;
      m_pend = 1'b0;
      @(posedge clk);
      #5;
      check("R5", cal_req === 1'b0, cal_req, 0);
      @(negedge clk);
      cal_ack = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: every request rise is matched against the model
   bit req_q = 1'b0;
   always begin
      @(posedge clk);
      #5;
      if (rst_n) begin
         if (cal_req && !req_q) begin
            if (exp_q.size() == 0) begin
               check("R7", 1'b0, tick_no, 0);
            end else begin
               int e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, tick_no == e, tick_no, e);
            end
         end
         req_q = cal_req;
      end
   end

   initial begin
      #(20 * 150000);
      check("watchdog", 1'b0, 0, 1);
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1", cal_req === 1'b0, cal_req, 0);
      read_check("R1", 8'h2C, 32'h0);

      // R2 map and width
      write_reg(8'h2C, 32'h0000_0005);
      read_check("R2", 8'h2C, 32'h5);
      write_reg(8'h2C, 32'hFFFF_1234);
      read_check("R2", 8'h2C, 32'h1234);
      read_check("R2", 8'h28, 32'h0);
      write_reg(8'h30, 32'h0000_0077);
      read_check("R2", 8'h2C, 32'h1234);
      write_reg(8'h2C, 32'h0000_C852);
      read_check("R2", 8'h2C, 32'hC852);

      // R3 write protect
      wp_en = 1'b1;
      write_reg(8'h2C, 32'h0000_0007);
      read_check("R3", 8'h2C, 32'hC852);
      wp_en = 1'b0;

      // R4 / R10: interval of three ticks
      write_reg(8'h2C, 32'h3);
      idle(40);
      check("R10", cal_req === 1'b0, cal_req, 0);
      ticks(2, "R4");
      idle(20);
      check("R4", cal_req === 1'b0, cal_req, 0);
      ticks(1, "R4");
      idle(10);
      check("R5", cal_req === 1'b1, cal_req, 1);

      // R7: expiry while pending dropped; R6: reload keeps going
      ticks(3, "R7");
      check("R7", exp_q.size() == 0, exp_q.size(), 0);
      ack_req();
      idle(5);
      check("R7", cal_req === 1'b0, cal_req, 0);
      ticks(3, "R6");
      idle(2);
      check("R6", cal_req === 1'b1, cal_req, 1);
      ack_req();

      // R9: restart mid-countdown
      write_reg(8'h2C, 32'h4);
      ticks(2, "R9");
      write_reg(8'h2C, 32'h2);
      ticks(1, "R9");
      idle(2);
      check("R9", cal_req === 1'b0, cal_req, 0);
      ticks(1, "R9");
      idle(2);
      check("R9", cal_req === 1'b1, cal_req, 1);
      ack_req();

      // boundary: interval of one
      write_reg(8'h2C, 32'h1);
      for (int i = 0; i < 3; i++) begin
         ticks(1, "R4");
         ack_req();
      end

      // R8: zero disables
      write_reg(8'h2C, 32'h0);
      ticks(12, "R8");
      idle(4);
      check("R8", cal_req === 1'b0, cal_req, 0);

      idle(4);
      check("R4", exp_q.size() == 0, exp_q.size(), 0);
      finish_run();
   end
endmodule